// File: doc/BRIEF.md
# Pin Controller with Interrupt Detection

This block drives and senses up to 32 general-purpose pins through registers on a simple 32-bit peripheral bus. Each pin can be handed to an alternate function or kept under register control. Under register control it can be set as an input or as an output, and as an output it has its own drive enable and drive value. The pin levels go through a two-stage synchroniser. Software reads the synchronised levels from a register, and the same levels feed the interrupt logic.

Each pin has its own interrupt detector. The detector works either on a level or on an edge, with a chosen polarity. In edge mode an extra option makes it respond to both edges. A detected event sets a pending bit. A single interrupt line is raised while any pending bit is not masked. Software cannot write the mask register directly: one register clears mask bits and another sets them, one write-1 bit per pin. Reading the pending register returns the pending bits and clears them in the same access. There is no acknowledge register.

The bus side is a small access sequencer with three states. ACC_IDLE means no access happened in the last cycle. ACC_WRITE means a write strobe was taken. ACC_READ means a read strobe was taken and the read word is on the data output. The transitions are evaluated every cycle: a write strobe moves the sequencer to ACC_WRITE, otherwise a read strobe moves it to ACC_READ, and otherwise it returns to ACC_IDLE.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the registers read as follows. The mask (0x14) reads all ones on bits [NPINS-1:0] and the direction register (0x04) reads all ones. Alternate select (0x00), output enable (0x08), output value (0x0C), mode (0x24), polarity (0x28) and both-edge (0x2C) read zero. Bits above NPINS-1 always read zero.
- R2: The registers at 0x00, 0x04, 0x08, 0x0C, 0x24, 0x28 and 0x2C read back the value last written, bit per pin.
- R3: When a pin's alternate-select bit is 1, pin_out and pin_oe follow alt_out_i and alt_oe_i. When it is 0, pin_out follows the output-value bit, and pin_oe is the output-enable bit ANDed with NOT direction (direction 1 = input, so drive is off).
- R4: The input register (0x10) returns pin_in as delayed by two synchronising flops. Writes to it are ignored. alt_in_o passes pin_in through unchanged.
- R5: Writing 1 to a bit at 0x18 clears that mask bit. Writing 1 to a bit at 0x1C sets it. Bits written as 0 leave the mask unchanged.
- R6: In level mode (mode bit 1), polarity 1 keeps the pending bit set while the synchronised level is high, and polarity 0 keeps it set while the level is low. A level that is still active after a read that clears the bit stays pending.
- R7: In edge mode (mode bit 0), with the both-edge bit 0, polarity 1 sets the pending bit on a rising edge and polarity 0 sets it on a falling edge.
- R8: In edge mode, the both-edge bit 1 sets the pending bit on either edge. In level mode the both-edge bit has no effect.
- R9: A read of 0x20 returns the pending bits and clears them. An event detected in the same cycle as that read stays pending.
- R10: irq_o is 1 exactly when some pin has its pending bit set and its mask bit 0. Pending bits are set regardless of the mask.
- R11: Read data appears in the cycle after bus_rd is taken and is zero in every other cycle. Unmapped offsets read zero. A bus_rd raised together with bus_wr is ignored, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Drive value to the pads |
| pin_oe | output | NPINS | Drive enable to the pads |
| alt_out_i | input | NPINS | Alternate-function drive value |
| alt_oe_i | input | NPINS | Alternate-function drive enable |
| alt_in_o | output | NPINS | Pin levels passed to the alternate function |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The pad multiplexer is swept over every direction pattern of a four-pin instance, combined with four alternate-select patterns. This separates alternate routing, input direction and the drive enable. All sixteen input patterns are read back, which checks the synchroniser path. For pin 0, all eight combinations of mode, polarity and both-edge see the same low-high-low sequence, with two reads after each change. The first read tells an edge event apart from a level event, and the second read tells a level that is still active apart from one that was cleared. Separate cases place an edge event on the same cycle as a pending read, and toggle the mask around a pending bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_ALT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OE   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IDIS = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_POL  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_BOTH = 8'h2C;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] dly_o
);
    logic [NPINS-1:0] stage1_q;
    logic [NPINS-1:0] stage2_q;
    logic [NPINS-1:0] stage3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            stage3_q <= '0;
        end else begin
            stage1_q <= pin_in;
            stage2_q <= stage1_q;
            stage3_q <= stage2_q;
        end
    end

    assign sync_o = stage2_q;
    assign dly_o  = stage3_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_i,
    input  logic [NPINS-1:0] dly_i,
    input  logic [NPINS-1:0] lvl_mode_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] both_i,
    input  logic             clr_i,
    output logic [NPINS-1:0] status_o
);
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] status_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise = sync_i[i] & ~dly_i[i];
        assign fall = ~sync_i[i] & dly_i[i];
        always_comb begin
            if (lvl_mode_i[i]) begin
                evt[i] = (sync_i[i] == pol_i[i]);
            end else if (both_i[i]) begin
                evt[i] = rise | fall;
            end else begin
                evt[i] = pol_i[i] ? rise : fall;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (clr_i ? '0 : status_q) | evt;
        end
    end

    assign status_o = status_q;

    // R9
    clr_keeps_only_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((status_q & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              rd_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [NPINS-1:0]  in_val_i,
    input  logic [NPINS-1:0]  status_i,
    output logic              stat_clr_o,
    output logic [NPINS-1:0]  alt_sel_o,
    output logic [NPINS-1:0]  dir_o,
    output logic [NPINS-1:0]  oe_o,
    output logic [NPINS-1:0]  out_val_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  lvl_mode_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  both_o
);
    acc_state_e       state_q;
    acc_state_e       state_d;
    logic [NPINS-1:0] wbits;
    logic             rd_go;
    logic [BUS_W-1:0] rd_mux;
    logic [BUS_W-1:0] read_q;

    logic [NPINS-1:0] alt_q, dir_q, oe_q, out_q, mask_q, mode_q, pol_q, both_q;

    assign wbits = wdata_i[NPINS-1:0];
    assign rd_go = rd_i && !wr_i;
    assign stat_clr_o = rd_go && (addr_i == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_q  <= '0;
            dir_q  <= '1;
            oe_q   <= '0;
            out_q  <= '0;
            mask_q <= '1;
            mode_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_ALT:  alt_q  <= wbits;
                OFS_DIR:  dir_q  <= wbits;
                OFS_OE:   oe_q   <= wbits;
                OFS_OUT:  out_q  <= wbits;
                OFS_IEN:  mask_q <= mask_q & ~wbits;
                OFS_IDIS: mask_q <= mask_q | wbits;
                OFS_MODE: mode_q <= wbits;
                OFS_POL:  pol_q  <= wbits;
                OFS_BOTH: both_q <= wbits;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr_i)
            OFS_ALT:  rd_mux[NPINS-1:0] = alt_q;
            OFS_DIR:  rd_mux[NPINS-1:0] = dir_q;
            OFS_OE:   rd_mux[NPINS-1:0] = oe_q;
            OFS_OUT:  rd_mux[NPINS-1:0] = out_q;
            OFS_IN:   rd_mux[NPINS-1:0] = in_val_i;
            OFS_MASK: rd_mux[NPINS-1:0] = mask_q;
            OFS_STAT: rd_mux[NPINS-1:0] = status_i;
            OFS_MODE: rd_mux[NPINS-1:0] = mode_q;
            OFS_POL:  rd_mux[NPINS-1:0] = pol_q;
            OFS_BOTH: rd_mux[NPINS-1:0] = both_q;
            default:  rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            read_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_go) begin
                read_q <= rd_mux;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_WRITE, ACC_READ: begin
                if (wr_i) begin
                    state_d = ACC_WRITE;
                end else if (rd_i) begin
                    state_d = ACC_READ;
                end else begin
                    state_d = ACC_IDLE;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // output process
    always_comb begin
        rdata_o = '0;
        unique case (state_q)
            ACC_READ:           rdata_o = read_q;
            ACC_IDLE, ACC_WRITE: rdata_o = '0;
            default:            rdata_o = '0;
        endcase
    end

    assign alt_sel_o  = alt_q;
    assign dir_o      = dir_q;
    assign oe_o       = oe_q;
    assign out_val_o  = out_q;
    assign mask_o     = mask_q;
    assign lvl_mode_o = mode_q;
    assign pol_o      = pol_q;
    assign both_o     = both_q;

    // R5
    en_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_IEN) |=> ((mask_o & $past(wdata_i[NPINS-1:0])) == '0));

    // R5
    dis_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_IDIS) |=>
            ((mask_o & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0])));

    // R11
    no_stray_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    input  logic [NPINS-1:0]  alt_out_i,
    input  logic [NPINS-1:0]  alt_oe_i,
    output logic [NPINS-1:0]  alt_in_o,
    output logic              irq_o
);
    logic [NPINS-1:0] sync_v, dly_v, status_v;
    logic [NPINS-1:0] alt_sel, dir, oe, out_val, mask, lvl_mode, pol, both;
    logic             stat_clr;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_o (sync_v),
        .dly_o  (dly_v)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_v),
        .dly_i      (dly_v),
        .lvl_mode_i (lvl_mode),
        .pol_i      (pol),
        .both_i     (both),
        .clr_i      (stat_clr),
        .status_o   (status_v)
    );

    gpio_reg_bank #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wr_i       (bus_wr),
        .wdata_i    (bus_wdata),
        .rd_i       (bus_rd),
        .rdata_o    (bus_rdata),
        .in_val_i   (sync_v),
        .status_i   (status_v),
        .stat_clr_o (stat_clr),
        .alt_sel_o  (alt_sel),
        .dir_o      (dir),
        .oe_o       (oe),
        .out_val_o  (out_val),
        .mask_o     (mask),
        .lvl_mode_o (lvl_mode),
        .pol_o      (pol),
        .both_o     (both)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        assign pin_out[i] = alt_sel[i] ? alt_out_i[i] : out_val[i];
        assign pin_oe[i]  = alt_sel[i] ? alt_oe_i[i] : (oe[i] & ~dir[i]);
    end

    assign alt_in_o = pin_in;
    assign irq_o    = |(status_v & ~mask);

    // R9
    stat_read_returns_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (bus_rdata[NPINS-1:0] == $past(status_v)));

    // R10
    irq_needs_open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask != {NPINS{1'b1}}));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    import gpio_irq_pkg::*;

    localparam int N = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [BUS_W-1:0]  bus_rdata;
    logic [N-1:0]      pin_in = '0;
    logic [N-1:0]      pin_out, pin_oe, alt_in_o;
    logic [N-1:0]      alt_out_i = 4'hC;
    logic [N-1:0]      alt_oe_i = 4'h3;
    logic              irq_o;

    int vectors = 0;
    int miscompares = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i), .alt_in_o(alt_in_o),
        .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [N-1:0] exp_oe, exp_out;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        bus_read(OFS_MASK, rv); check("R1 mask", rv, 32'h0000_000F);
        bus_read(OFS_DIR,  rv); check("R1 dir",  rv, 32'h0000_000F);
        bus_read(OFS_ALT,  rv); check("R1 alt",  rv, 32'h0);
        bus_read(OFS_OE,   rv); check("R1 oe",   rv, 32'h0);
        bus_read(OFS_OUT,  rv); check("R1 out",  rv, 32'h0);
        bus_read(OFS_MODE, rv); check("R1 mode", rv, 32'h0);
        bus_read(OFS_POL,  rv); check("R1 pol",  rv, 32'h0);
        bus_read(OFS_BOTH, rv); check("R1 both", rv, 32'h0);
        check("R11 idle rdata", bus_rdata, 32'h0);

        // R2 readback
        bus_write(OFS_MODE, 32'hFFFF_FFF6); bus_read(OFS_MODE, rv); check("R2 mode", rv, 32'h6);
        bus_write(OFS_POL,  32'h9);         bus_read(OFS_POL,  rv); check("R2 pol",  rv, 32'h9);
        bus_write(OFS_BOTH, 32'h5);         bus_read(OFS_BOTH, rv); check("R2 both", rv, 32'h5);
        bus_write(OFS_MODE, 32'h0); bus_write(OFS_POL, 32'h0); bus_write(OFS_BOTH, 32'h0);

        // R3 pad sweep
        for (int b = 0; b < 4; b++) begin
            logic [N-1:0] bsel;
            bsel = (b == 0) ? 4'h0 : (b == 1) ? 4'hF : (b == 2) ? 4'h5 : 4'hA;
            bus_write(OFS_ALT, {28'h0, bsel});
            for (int d = 0; d < 16; d++) begin
                logic [N-1:0] dv, ov, vv;
                dv = d[N-1:0]; ov = dv ^ 4'h6; vv = dv ^ 4'h9;
                bus_write(OFS_DIR, {28'h0, dv});
                bus_write(OFS_OE,  {28'h0, ov});
                bus_write(OFS_OUT, {28'h0, vv});
                exp_oe  = (bsel & alt_oe_i)  | (~bsel & ov & ~dv);
                exp_out = (bsel & alt_out_i) | (~bsel & vv);
                check("R3 pad", {24'h0, pin_oe, pin_out}, {24'h0, exp_oe, exp_out});
            end
        end
        bus_write(OFS_ALT, 32'h0);
        bus_write(OFS_DIR, 32'hF);

        // R4 input sweep
        for (int p = 0; p < 16; p++) begin
            pin_in = p[N-1:0];
            check("R4 alt_in", {28'h0, alt_in_o}, {28'h0, p[N-1:0]});
            idle(3);
            bus_read(OFS_IN, rv);
            check("R4 in value", rv, {28'h0, p[N-1:0]});
        end
        pin_in = '0; idle(4);
        bus_write(OFS_IN, 32'hF); bus_read(OFS_IN, rv); check("R4 write ignored", rv, 32'h0);

        // R11 unmapped and read with write
        bus_read(8'h30, rv); check("R11 unmapped", rv, 32'h0);
        bus_addr = OFS_OUT; bus_wdata = 32'h3; bus_wr = 1'b1; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R11 rd with wr", bus_rdata, 32'h0);
        bus_wr = 1'b0; bus_rd = 1'b0;
        bus_read(OFS_OUT, rv); check("R11 write kept", rv, 32'h3);

        // R6 R7 R8 mode sweep on pin 0
        bus_read(OFS_STAT, rv);
        for (int m = 0; m < 8; m++) begin
            logic t, v, a;
            t = m[2]; v = m[1]; a = m[0];
            bus_write(OFS_MODE, {31'h0, t});
            bus_write(OFS_POL,  {31'h0, v});
            bus_write(OFS_BOTH, {31'h0, a});
            pin_in = 4'h0; idle(6);
            bus_read(OFS_STAT, rv);
            bus_read(OFS_STAT, rv); check($sformatf("R6 low held m=%0d", m), rv, {31'h0, t & !v});
            pin_in = 4'h1; idle(6);
            bus_read(OFS_STAT, rv); check($sformatf("R7 R8 rise m=%0d", m), rv, {31'h0, t | a | v});
            bus_read(OFS_STAT, rv); check($sformatf("R6 high held m=%0d", m), rv, {31'h0, t & v});
            pin_in = 4'h0; idle(6);
            bus_read(OFS_STAT, rv); check($sformatf("R7 R8 fall m=%0d", m), rv, {31'h0, t | a | !v});
            bus_read(OFS_STAT, rv); check($sformatf("R6 low again m=%0d", m), rv, {31'h0, t & !v});
        end

        // R9 event on the read cycle: rising edge mode
        bus_write(OFS_MODE, 32'h0); bus_write(OFS_POL, 32'h1); bus_write(OFS_BOTH, 32'h0);
        idle(4);
        bus_read(OFS_STAT, rv);
        pin_in = 4'h1;
        idle(2);
        bus_read(OFS_STAT, rv); check("R9 read before event", rv, 32'h0);
        bus_read(OFS_STAT, rv); check("R9 event kept", rv, 32'h1);
        bus_read(OFS_STAT, rv); check("R9 cleared", rv, 32'h0);

        // R10 mask gating
        pin_in = 4'h0; idle(6);
        check("R10 masked idle", {31'h0, irq_o}, 32'h0);
        pin_in = 4'h1; idle(6);
        check("R10 pending but masked", {31'h0, irq_o}, 32'h0);
        bus_write(OFS_IEN, 32'h5);
        bus_read(OFS_MASK, rv); check("R5 enable clears", rv, 32'hA);
        check("R10 irq raised", {31'h0, irq_o}, 32'h1);
        bus_write(OFS_IEN, 32'h0);
        bus_read(OFS_MASK, rv); check("R5 zero write", rv, 32'hA);
        bus_write(OFS_IDIS, 32'h1);
        bus_read(OFS_MASK, rv); check("R5 disable sets", rv, 32'hB);
        check("R10 irq masked again", {31'h0, irq_o}, 32'h0);
        bus_write(OFS_IEN, 32'h1);
        check("R10 irq back", {31'h0, irq_o}, 32'h1);
        bus_read(OFS_STAT, rv); check("R9 status read", rv, 32'h1);
        check("R10 irq dropped after read", {31'h0, irq_o}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule